// File: doc/BRIEF.md
# Register-File LIFO Stack with Full/Empty Flags

This block is a last-in, first-out store built from flip-flops. It holds up to 2^PTR_W words of DATA_W bits each, with defaults of 64 words and 8 bits. A pointer register marks the top of the stack, and two flags show when the stack is full and when it is empty. Each cycle a client may request a push or a pop. A push stores `push_data`. A pop copies the top word into an output data register, which keeps that value until the next pop that is accepted.

The pointer counts modulo the depth. On a push it advances first and the word is written at the new pointer value. On a pop the word at the current pointer is read first and the pointer steps back afterwards. The flags are set only when an operation leaves the pointer at zero. This lets all of the locations hold data with a pointer no wider than the address. The block refuses requests it cannot honour and reports each refusal with a one-cycle error pulse. A push and a pop asserted together are treated as no request.

Top module: `regstk_top`

## Requirements
- R1: After synchronous reset, the pointer is 0, the empty flag is 1, the full flag is 0, the error output is 0 and the output data register is 0.
- R2: An accepted push advances the pointer by one, modulo the depth, and clears the empty flag. A push is accepted when push is requested, pop is not, and the stack is not full.
- R3: An accepted push that leaves the pointer at 0 sets the full flag. Starting from reset, this happens on the 64th push with the defaults.
- R4: An accepted pop loads the word at the current pointer into the output data register and then steps the pointer back by one. A pop is accepted when pop is requested, push is not, and the stack is not empty. Words come back in the reverse of the order they were pushed.
- R5: An accepted pop clears the full flag. If it leaves the pointer at 0, it sets the empty flag.
- R6: A push while full changes no pointer, flag or stored word. The error output is high for exactly the following cycle.
- R7: A pop while empty changes no pointer, flag or output data. The error output is high for exactly the following cycle.
- R8: A push and a pop requested in the same cycle change no state and raise no error.
- R9: The output data register changes only on an accepted pop, and the error output is low after every cycle that held no refused request.
- R10: The full and empty flags are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Request to store `push_data` on top of the stack |
| pop_req | input | 1 | Request to remove the top word into `pop_data` |
| push_data | input | DATA_W | Word to be pushed |
| pop_data | output | DATA_W | Output data register holding the most recently popped word |
| top_ptr | output | PTR_W | Current stack pointer |
| full | output | 1 | Stack full flag |
| empty | output | 1 | Stack empty flag |
| err | output | 1 | One-cycle pulse after a refused push or pop |

## Verification
All outputs are registered, so each request affects the pointer, flags, output data and error pulse at the first rising edge after the request is presented. Nothing has a longer latency. The bench drives each request on a falling edge and queues the outputs expected after the next rising edge. A monitor samples shortly after that edge and compares the outputs against the front of the queue. Refused pushes are shown to leave the stored words untouched by popping the whole stack afterwards and checking the words in reverse order.

// File: rtl/regstk_pkg.sv
package regstk_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_REFUSE_PUSH,
        OP_REFUSE_POP
    } stk_op_e;

    typedef struct packed {
        logic full;
        logic empty;
    } stk_flags_t;

    function automatic stk_op_e classify_op(
        input logic       push,
        input logic       pop,
        input stk_flags_t flags
    );
        stk_op_e op;
        op = OP_IDLE;
        if (push && !pop) op = flags.full  ? OP_REFUSE_PUSH : OP_PUSH;
        if (pop && !push) op = flags.empty ? OP_REFUSE_POP  : OP_POP;
        return op;
    endfunction

endpackage

// File: rtl/regstk_store.sv
module regstk_store #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // One write-enabled register per location.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(i))) cells[i] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/regstk_ctrl.sv
module regstk_ctrl
    import regstk_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] ptr,
    output stk_flags_t       flags,
    output logic             err,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             rd_en
);
    stk_op_e          op;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    always_comb begin
        op      = classify_op(push_req, pop_req, flags);
        ptr_inc = ptr + PTR_W'(1);
        ptr_dec = ptr - PTR_W'(1);
        wr_en   = (op == OP_PUSH);
        wr_addr = ptr_inc;          // store at the advanced pointer
        rd_en   = (op == OP_POP);   // read at the current pointer
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            flags <= '{full: 1'b0, empty: 1'b1};
            err   <= 1'b0;
        end else begin
            err <= (op == OP_REFUSE_PUSH) || (op == OP_REFUSE_POP);
            unique case (op)
                OP_PUSH: begin
                    ptr         <= ptr_inc;
                    flags.empty <= 1'b0;
                    flags.full  <= (ptr_inc == '0);
                end
                OP_POP: begin
                    ptr         <= ptr_dec;
                    flags.full  <= 1'b0;
                    flags.empty <= (ptr_dec == '0);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regstk_top.sv
module regstk_top
    import regstk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic [PTR_W-1:0]  top_ptr,
    output logic              full,
    output logic              empty,
    output logic              err
);
    stk_flags_t        flags;
    logic              wr_en;
    logic              rd_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [DATA_W-1:0] rd_word;

    regstk_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .ptr      (top_ptr),
        .flags    (flags),
        .err      (err),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en)
    );

    regstk_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (push_data),
        .rd_addr (top_ptr),
        .rd_data (rd_word)
    );

    // Output data register: loads only on an accepted pop.
    always_ff @(posedge clk) begin
        if (rst)        pop_data <= '0;
        else if (rd_en) pop_data <= rd_word;
    end

    assign full  = flags.full;
    assign empty = flags.empty;

endmodule

// File: rtl/regstk_chk.sv
module regstk_chk #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              push_req,
    input logic              pop_req,
    input logic [DATA_W-1:0] pop_data,
    input logic [PTR_W-1:0]  top_ptr,
    input logic              full,
    input logic              empty,
    input logic              err
);
    logic push_ok, pop_ok, push_bad, pop_bad, both;
    assign push_ok  = push_req && !pop_req && !full;
    assign pop_ok   = pop_req && !push_req && !empty;
    assign push_bad = push_req && !pop_req && full;
    assign pop_bad  = pop_req && !push_req && empty;
    assign both     = push_req && pop_req;

    assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> (top_ptr == PTR_W'($past(top_ptr) + PTR_W'(1))) && !empty);

    assert_full_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> (full == (top_ptr == '0)));

    assert_pop_step_R4: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> (top_ptr == PTR_W'($past(top_ptr) - PTR_W'(1))));

    assert_empty_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        pop_ok |=> !full && (empty == (top_ptr == '0)));

    assert_refuse_push_R6: assert property (@(posedge clk) disable iff (rst)
        push_bad |=> err && full && $stable(top_ptr) && $stable(pop_data));

    assert_refuse_pop_R7: assert property (@(posedge clk) disable iff (rst)
        pop_bad |=> err && empty && $stable(top_ptr) && $stable(pop_data));

    assert_both_nop_R8: assert property (@(posedge clk) disable iff (rst)
        both |=> !err && $stable(top_ptr) && $stable(full) && $stable(empty) && $stable(pop_data));

    assert_hold_data_R9: assert property (@(posedge clk) disable iff (rst)
        !pop_ok |=> $stable(pop_data));

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(push_bad || pop_bad) |=> !err);

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

bind regstk_top regstk_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .pop_data (pop_data),
    .top_ptr  (top_ptr),
    .full     (full),
    .empty    (empty),
    .err      (err)
);

// File: tb/sim_regstk_top.sv
`timescale 1ns/1ps
module sim_regstk_top;
    localparam int DW    = 8;
    localparam int PW    = 6;
    localparam int DEPTH = 1 << PW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_req = 1'b0;
    logic          pop_req  = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] pop_data;
    logic [PW-1:0] top_ptr;
    logic          full, empty, err;

    always #2.5 clk = ~clk;   // 200 MHz

    regstk_top #(.DATA_W(DW), .PTR_W(PW)) u0 (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .pop_data(pop_data), .top_ptr(top_ptr),
        .full(full), .empty(empty), .err(err)
    );

    typedef struct {
        logic [PW-1:0] ptr;
        logic          full;
        logic          empty;
        logic          err;
        logic [DW-1:0] data;
        int            req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Reference model
    logic [DW-1:0] m_mem [DEPTH];
    logic [PW-1:0] m_ptr  = '0;
    logic          m_full = 1'b0;
    logic          m_empty = 1'b1;
    logic [DW-1:0] m_data = '0;

    function automatic string req_name(int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Driver: present one request at a falling edge and queue the expected outcome.
    task automatic step(input bit p, input bit q, input logic [DW-1:0] d);
        exp_t e;
        @(negedge clk);
        push_req = p; pop_req = q; push_data = d;
        e.err = 1'b0;
        if (p && !q && !m_full) begin                 // R2 / R3
            m_ptr = m_ptr + PW'(1);
            m_mem[m_ptr] = d;
            m_empty = 1'b0;
            m_full = (m_ptr == '0);
            e.req = m_full ? 3 : 2;
        end else if (q && !p && !m_empty) begin       // R4 / R5
            m_data = m_mem[m_ptr];
            m_ptr = m_ptr - PW'(1);
            m_full = 1'b0;
            m_empty = (m_ptr == '0);
            e.req = m_empty ? 5 : 4;
        end else if (p && !q) begin                   // R6 refused push
            e.err = 1'b1; e.req = 6;
        end else if (q && !p) begin                   // R7 refused pop
            e.err = 1'b1; e.req = 7;
        end else if (p && q) begin                    // R8 both at once
            e.req = 8;
        end else begin                                // R9 idle hold
            e.req = 9;
        end
        e.ptr = m_ptr; e.full = m_full; e.empty = m_empty; e.data = m_data;
        exp_q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge; R10 flag exclusion checked too.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (top_ptr !== e.ptr || full !== e.full || empty !== e.empty ||
                err !== e.err || pop_data !== e.data) begin
                n_fail++;
                $display("FAIL %s: ptr=%0d full=%b empty=%b err=%b data=%h, expected ptr=%0d full=%b empty=%b err=%b data=%h",
                         req_name(e.req), top_ptr, full, empty, err, pop_data,
                         e.ptr, e.full, e.empty, e.err, e.data);
            end
            n_checks++;
            if (full && empty) begin
                n_fail++;
                $display("FAIL R10: full=%b empty=%b, expected not both high", full, empty);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: run hung, expected completion");
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        n_checks++;
        if (top_ptr !== '0 || full !== 1'b0 || empty !== 1'b1 || err !== 1'b0 || pop_data !== '0) begin
            n_fail++;
            $display("FAIL R1: ptr=%0d full=%b empty=%b err=%b data=%h, expected 0 0 1 0 00",
                     top_ptr, full, empty, err, pop_data);
        end
        step(0, 1, '0);            // R7 pop while empty
        step(0, 0, '0);            // R9 error drops again
        step(1, 1, 8'h11);         // R8 both while empty
        for (int i = 0; i < 3; i++) step(1, 0, DW'(8'hA0 + i));   // R2
        step(1, 1, 8'h55);         // R8 both mid-stack
        for (int i = 0; i < 3; i++) step(0, 1, '0);               // R4 LIFO, R5 empty
        step(0, 0, '0);            // R9 hold popped word
        step(1, 0, 8'h77);         // R9 push leaves pop_data unchanged
        step(0, 1, '0);
        for (int i = 0; i < DEPTH; i++) step(1, 0, DW'(i * 3 + 1)); // R3 full on last
        step(1, 0, 8'hEE);         // R6 push while full
        step(1, 0, 8'hDD);         // R6 again
        step(1, 1, 8'hCC);         // R8 while full
        for (int i = 0; i < DEPTH; i++) begin                      // R4/R5 drain, R6 contents intact
            step(0, 1, '0);
            if (i % 7 == 0) step(0, 0, '0);
        end
        step(0, 1, '0);            // R7 after drain
        for (int i = 0; i < 20; i++) step(i % 3 != 2, i % 3 == 2, DW'(i * 11)); // mixed pattern
        step(0, 0, '0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule